// File: doc/BRIEF.md
# Loss-of-Signal Declaration Timer

This block debounces the loss-of-signal flag of one 2.048 Mbit/s line receiver. An analog front end outside the block decides, once per 488 ns bit interval, whether the line carried qualifying transitions. The block takes that decision as the one-bit level `sig_present`, together with a one-cycle strobe `bit_tick` that marks the interval. It raises `los` only after an unbroken run of empty intervals. It drops `los` only after an unbroken run of good intervals. Any interval that goes the other way restarts the run.

The select input `auto_mode` chooses between two delay modes. When it is 1, only the base run of `RUN_LEN` intervals is applied. When it is 0, a further 2048 periods of a slow asynchronous user clock `ext_tclk` are added after the base run, in both directions. The extension never replaces the base run. Both `auto_mode` and `ext_tclk` are meant to be tied high when unused. Seven copies of the block can share one `ext_tclk`. `run_count` exposes the current run length for debug.

Top module: `los_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `los` becomes 1 and `run_count` becomes 0 after that edge.
- R2: With `auto_mode`=1 and `los`=0, a run of `RUN_LEN` (default 32, allowed 11 to 254) consecutive ticks with `sig_present`=0 sets `los` to 1 on the second clock edge after the last tick. A run of `RUN_LEN`-1 such ticks leaves `los` at 0.
- R3: With `auto_mode`=1 and `los`=1, a run of `RUN_LEN` consecutive ticks with `sig_present`=1 clears `los` to 0 on the same timing as R2. A run of `RUN_LEN`-1 such ticks leaves `los` at 1.
- R4: A tick whose `sig_present` differs from the level that extends the current run sets `run_count` to 0 and leaves `los` unchanged.
- R5: `sig_present` is looked at only on cycles with `bit_tick`=1. Changes on other cycles leave `run_count` and `los` unchanged.
- R6: With `auto_mode`=0, once the base run is complete, `los` toggles on the 2048th synchronised rising edge of `ext_tclk`, in either direction. It does not toggle on the 2047th edge.
- R7: Rising edges of `ext_tclk` that arrive before the base run is complete are not counted. The extended delay is therefore never shorter than the base run.
- R8: A breaking tick during the extension phase also discards the extension edges already counted.
- R9: `run_count` gives the number of consecutive qualifying ticks in the current run. It saturates at `RUN_LEN` and returns to 0 after each toggle of `los`.
- R10: If `auto_mode` changes to 1 while the extension phase is in progress, `los` toggles within two clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe, one per bit interval |
| sig_present | input | 1 | 1 = the interval carried qualifying transitions |
| auto_mode | input | 1 | 1 = base delay only, 0 = base delay plus clock extension |
| ext_tclk | input | 1 | Slow asynchronous user timing clock (idle high) |
| los | output | 1 | Loss-of-signal flag, 1 = loss declared |
| run_count | output | $clog2(RUN_LEN+1) | Current consecutive-interval run length |

## Verification
The hardest case to reach from the ports is R7. It needs a full 2047 user-clock edges to arrive while the base run is still one interval short. If the design counted those edges too early, a single further edge would then toggle the flag. The bench therefore stops the run at `RUN_LEN`-1 intervals and pulses `ext_tclk` 2047 times. It then completes the run and delivers exactly one edge, expecting no toggle. It then delivers 2047 more edges and expects the toggle only on the last one. The R8 restart is covered the same way: 1000 edges are counted, a breaking interval is injected, and the run is rebuilt from zero.

// File: rtl/los_pkg.sv
package los_pkg;

    localparam int DEF_RUN_LEN     = 32;
    localparam int DEF_EXT_PERIODS = 2048;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic {
        MODE_EXTENDED = 1'b0,
        MODE_AUTO     = 1'b1
    } los_mode_e;

    // Classification of one sampled bit interval against the current flag.
    typedef struct packed {
        logic hit;   // interval extends the current run
        logic miss;  // interval breaks the current run
    } ivl_class_t;

    function automatic ivl_class_t classify(input logic tick,
                                            input logic present,
                                            input logic flag);
        ivl_class_t c;
        // While lost, good intervals count toward clearing; otherwise
        // empty intervals count toward declaring.
        c.hit  = tick & (present == flag);
        c.miss = tick & (present != flag);
        return c;
    endfunction

endpackage

// File: rtl/los_edge_sync.sv
module los_edge_sync #(
    parameter int STAGES = los_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b1;
        else     last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;

endmodule

// File: rtl/los_run_counter.sv
module los_run_counter #(
    parameter int RUN_LEN = los_pkg::DEF_RUN_LEN,
    localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

    always_ff @(posedge clk) begin
        if (rst || restart)        count <= '0;
        else if (hit && !full)     count <= count + 1'b1;
    end

    assign full = (count == LIMIT);

endmodule

// File: rtl/los_ext_counter.sv
module los_ext_counter #(
    parameter int EXT_PERIODS = los_pkg::DEF_EXT_PERIODS,
    localparam int EXT_W      = $clog2(EXT_PERIODS)
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic edge_in,
    input  logic restart,
    output logic last
);
    localparam logic [EXT_W-1:0] LAST_VAL = EXT_W'(EXT_PERIODS - 1);

    logic [EXT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)          cnt <= '0;
        else if (enable && edge_in)  cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_VAL);

endmodule

// File: rtl/los_timer.sv
module los_timer
    import los_pkg::*;
#(
    parameter int RUN_LEN     = DEF_RUN_LEN,
    parameter int EXT_PERIODS = DEF_EXT_PERIODS,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int CNT_W      = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             sig_present,
    input  logic             auto_mode,
    input  logic             ext_tclk,
    output logic             los,
    output logic [CNT_W-1:0] run_count
);
    generate
        if (RUN_LEN < 11 || RUN_LEN > 254) begin : g_bad_len
            $error("RUN_LEN must lie between 11 and 254");
        end
        if (EXT_PERIODS < 2) begin : g_bad_ext
            $error("EXT_PERIODS must be at least 2");
        end
    endgenerate

    ivl_class_t ivl;
    los_mode_e  mode;
    logic       los_q;
    logic       base_done;
    logic       ext_edge;
    logic       ext_last;
    logic       flip;

    assign mode = los_mode_e'(auto_mode);
    assign ivl  = classify(bit_tick, sig_present, los_q);

    los_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_tclk),
        .rise     (ext_edge)
    );

    los_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk     (clk),
        .rst     (rst),
        .hit     (ivl.hit),
        .restart (ivl.miss | flip),
        .count   (run_count),
        .full    (base_done)
    );

    los_ext_counter #(.EXT_PERIODS(EXT_PERIODS)) u_ext (
        .clk     (clk),
        .rst     (rst),
        .enable  (base_done && mode == MODE_EXTENDED),
        .edge_in (ext_edge),
        .restart (ivl.miss | flip | ~base_done),
        .last    (ext_last)
    );

    // A breaking interval always wins over a pending toggle.
    always_comb begin
        flip = 1'b0;
        if (base_done && !ivl.miss) begin
            if (mode == MODE_AUTO)          flip = 1'b1;
            else if (ext_edge && ext_last)  flip = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       los_q <= 1'b1;
        else if (flip) los_q <= ~los_q;
    end

    assign los = los_q;

endmodule

// File: rtl/los_timer_chk.sv
module los_timer_chk #(
    parameter int RUN_LEN = los_pkg::DEF_RUN_LEN,
    localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_tick,
    input logic             sig_present,
    input logic             auto_mode,
    input logic             ext_edge,
    input logic             los,
    input logic [CNT_W-1:0] run_count
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (los && run_count == '0));

    // Flag changes only once a full base run has been seen (R2, R3).
    p_full_run_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(los) |-> $past(run_count) == CNT_W'(RUN_LEN));

    p_break_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && sig_present != los) |=> (run_count == '0 && $stable(los)));

    p_no_tick_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!bit_tick && run_count != CNT_W'(RUN_LEN)) |=> ($stable(run_count) && $stable(los)));

    p_ext_edge_needed_r6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(los) && !$past(auto_mode)) |-> $past(ext_edge));

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        run_count <= CNT_W'(RUN_LEN));

endmodule

bind los_timer los_timer_chk #(.RUN_LEN(RUN_LEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_tick    (bit_tick),
    .sig_present (sig_present),
    .auto_mode   (auto_mode),
    .ext_edge    (ext_edge),
    .los         (los),
    .run_count   (run_count)
);

// File: tb/los_timer_test.sv
module los_timer_test;
    localparam int N     = 32;
    localparam int EXT   = 2048;
    localparam int CNT_W = $clog2(N + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bit_tick = 1'b0;
    logic             sig_present = 1'b0;
    logic             auto_mode = 1'b1;
    logic             ext_tclk = 1'b1;
    logic             los;
    logic [CNT_W-1:0] run_count;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    los_timer uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .sig_present(sig_present),
        .auto_mode(auto_mode), .ext_tclk(ext_tclk), .los(los), .run_count(run_count)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic interval(input logic present);
        @(negedge clk); sig_present = present; bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic intervals(input logic present, input int n);
        for (int i = 0; i < n; i++) interval(present);
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_tclk = 1'b0;
            repeat (3) @(negedge clk);
            ext_tclk = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(los == 1'b1, "R1 los", los, 1);
        check(run_count == 0, "R1 count", run_count, 0);
    endtask

    task automatic t_auto_clear;
        auto_mode = 1'b1;
        intervals(1'b1, N - 1);
        check(los == 1'b1, "R3 short run", los, 1);
        check(run_count == N - 1, "R9 count", run_count, N - 1);
        interval(1'b1);
        check(los == 1'b0, "R3 cleared", los, 0);
        check(run_count == 0, "R9 count after toggle", run_count, 0);
    endtask

    task automatic t_auto_declare_break;
        intervals(1'b0, N - 1);
        check(los == 1'b0, "R2 short run", los, 0);
        interval(1'b1);
        check(run_count == 0, "R4 break count", run_count, 0);
        check(los == 1'b0, "R4 break los", los, 0);
        intervals(1'b0, N - 1);
        check(los == 1'b0, "R4 restarted run", los, 0);
        interval(1'b0);
        check(los == 1'b1, "R2 declared", los, 1);
        intervals(1'b1, N);
        check(los == 1'b0, "R3 cleared again", los, 0);
    endtask

    task automatic t_no_tick;
        interval(1'b1);
        intervals(1'b0, 5);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); sig_present = i[0];
        end
        @(negedge clk);
        check(run_count == 5, "R5 count held", run_count, 5);
        check(los == 1'b0, "R5 los held", los, 0);
    endtask

    task automatic t_ext_declare;
        auto_mode = 1'b0;
        interval(1'b1);
        intervals(1'b0, N - 1);
        ext_pulses(EXT - 1);
        check(los == 1'b0, "R7 early edges", los, 0);
        interval(1'b0);
        check(run_count == N, "R9 full count", run_count, N);
        ext_pulses(1);
        check(los == 1'b0, "R7 early edges not counted", los, 0);
        ext_pulses(EXT - 2);
        check(los == 1'b0, "R6 edge 2047", los, 0);
        ext_pulses(1);
        check(los == 1'b1, "R6 edge 2048 declares", los, 1);
    endtask

    task automatic t_ext_break_clear;
        intervals(1'b1, N);
        ext_pulses(1000);
        interval(1'b0);
        check(run_count == 0, "R8 break count", run_count, 0);
        check(los == 1'b1, "R8 break los", los, 1);
        intervals(1'b1, N);
        ext_pulses(EXT - 1);
        check(los == 1'b1, "R8 edges discarded", los, 1);
        ext_pulses(1);
        check(los == 1'b0, "R6 edge 2048 clears", los, 0);
    endtask

    task automatic t_saturate_switch;
        intervals(1'b0, N + 3);
        check(run_count == N, "R9 saturates", run_count, N);
        ext_pulses(10);
        check(los == 1'b0, "R10 still extending", los, 0);
        @(negedge clk); auto_mode = 1'b1;
        repeat (2) @(negedge clk);
        check(los == 1'b1, "R10 switch toggles", los, 1);
    endtask

    initial begin
        t_reset();
        t_auto_clear();
        t_auto_declare_break();
        t_no_tick();
        t_ext_declare();
        t_ext_break_clear();
        t_saturate_switch();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule